// File: doc/BRIEF.md
# Queued SPI Master

This block is a memory-mapped SPI master that works through a queue of up to sixteen byte transfers without help from the processor. Each queue slot has three parts: a byte to send, a byte that was received, and a command byte. Software fills the slots and sets a first-slot pointer and a last-slot pointer. It then sets a run bit in a control word. The engine shifts the slots in order, from the first pointer up to and including the last pointer, and wraps from slot 15 back to slot 0. It stores each received byte back into its slot. When the queue is finished it sets a done flag, and it can raise an interrupt request.

The shifting uses SPI mode 3 with 8-bit words, MSB first. The clock idles high, data changes while the clock is low, and data is sampled on the rising clock edge. Bit 7 of each slot's command byte decides whether chip select stays asserted into the next slot. A continue bit in the control word decides whether chip select stays asserted after the last slot. A one-hot select word picks which of the eight chip-select pins is driven. A write-lock bit is available so that software can claim the controller for a multi-part transaction.

The register bus uses word addresses with single-cycle writes and combinational reads. The map is: 0x00 clock control, 0x01 first-slot pointer, 0x02 last-slot pointer, 0x03 run control, 0x04 status, 0x05 device select, 0x06 write lock, 0x20-0x3F transmit words, 0x40-0x5F receive words, 0x60-0x6F command words.

Top module: `queued_spi_master`

## Requirements
- R1: After reset, all chip-select pins are high, the SPI clock is high, the status word reads 0, and the interrupt output is low.
- R2: Setting bit 6 of the run control word (address 0x03) starts a run. The run shifts the slots from the first pointer (0x01) to the last pointer (0x02), both inclusive, and wraps from slot 15 to slot 0. The byte sent for slot n is taken from word 0x20+2n and sent MSB first in SPI mode 3.
- R3: The byte received in slot n is read back from bit positions 7:0 of word 0x40+2n+1.
- R4: Each half-period of the SPI clock lasts D system-clock cycles. D is bits 7:0 of word 0x00, and any value below 8 is treated as 8.
- R5: When bit 7 of a slot's command byte (word 0x60+n) is set, chip select stays asserted into the next slot. When it is clear, chip select is released between the two slots. After the last slot, chip select is released unless both that slot's bit 7 and bit 7 of the run control word are set.
- R6: While chip select is asserted, each pin i of spi_cs_n is low exactly when bit i of the device select word (0x05) is set.
- R7: Bit 6 of the run control word reads 1 during a run and 0 after the run. Status bit 0 (0x04) becomes 1 when a run completes. Writing 0 to status bit 0 clears it.
- R8: The irq output is high when status bit 0 is 1 and bit 5 of the run control word is 1. Otherwise irq is low.
- R9: During a run, every register write is ignored except a write to the status word.
- R10: Bit 0 of the write-lock word (0x06) can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low chip selects |
| irq | output | 1 | Done interrupt request |

## Verification
The assertions check the following on every cycle:
- the SPI clock idles high whenever no byte is being shifted;
- MOSI is stable while the clock stays high;
- chip select covers every shifted bit;
- the pointer and clock configuration are frozen during a run;
- completion always sets the status flag.

Some behaviour can only be shown by the bench's scenarios, using a serial device model at the pins. These are: the order of the slots, including the wrap; the byte captured for each slot; the received bytes stored in the right receive words; the count of chip-select releases for each pattern of command bits; the clamped divider; and the fact that writes made during a run have no effect.

// File: rtl/qsm_pkg.sv
package qsm_pkg;
    localparam int QSM_SLOTS   = 16;
    localparam int QSM_AW      = 7;
    localparam int QSM_DW      = 32;
    localparam int QSM_CSW     = 8;
    localparam int QSM_MIN_DIV = 8;

    localparam logic [QSM_AW-1:0] A_CLKCTL = 7'h00;
    localparam logic [QSM_AW-1:0] A_FIRST  = 7'h01;
    localparam logic [QSM_AW-1:0] A_LAST   = 7'h02;
    localparam logic [QSM_AW-1:0] A_RUNCTL = 7'h03;
    localparam logic [QSM_AW-1:0] A_STATUS = 7'h04;
    localparam logic [QSM_AW-1:0] A_DEVSEL = 7'h05;
    localparam logic [QSM_AW-1:0] A_LOCK   = 7'h06;

    typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_XFER, SQ_GAP} seq_state_t;

    typedef struct packed {
        logic cont;
        logic ie;
    } runctl_t;

    function automatic logic [7:0] eff_div(input logic [7:0] d);
        return (d < 8'(QSM_MIN_DIV)) ? 8'(QSM_MIN_DIV) : d;
    endfunction
endpackage

// File: rtl/qsm_regfile.sv
module qsm_regfile
    import qsm_pkg::*;
#(
    parameter int SLOTS = QSM_SLOTS,
    parameter int AW    = QSM_AW,
    parameter int DW    = QSM_DW,
    parameter int CSW   = QSM_CSW,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          active,
    input  logic          done_set,
    input  logic          rx_we,
    input  logic [SW-1:0] slot,
    input  logic [7:0]    rx_data,
    output logic          start,
    output logic [SW-1:0] first_ptr,
    output logic [SW-1:0] last_ptr,
    output logic [7:0]    div,
    output runctl_t       runctl,
    output logic [CSW-1:0] devsel,
    output logic [7:0]    tx_byte,
    output logic          slot_hold,
    output logic          irq
);
    logic [DW-1:0]  clkctl_q;
    logic [SW-1:0]  first_q, last_q;
    runctl_t        rc_q;
    logic           stat_q, lock_q;
    logic [CSW-1:0] sel_q;
    logic [7:0]     tx_mem  [SLOTS];
    logic [7:0]     rx_mem  [SLOTS];
    logic [7:0]     cmd_mem [SLOTS];

    logic cfg_wr, is_tx, is_rx, is_cmd;
    assign cfg_wr = wr && !active;
    assign is_tx  = (addr[AW-1:AW-2] == 2'b01);
    assign is_rx  = (addr[AW-1:AW-2] == 2'b10);
    assign is_cmd = (addr[AW-1:AW-3] == 3'b110);
    assign start  = cfg_wr && (addr == A_RUNCTL) && wdata[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            clkctl_q <= '0;
            first_q  <= '0;
            last_q   <= '0;
            rc_q     <= '0;
            stat_q   <= 1'b0;
            lock_q   <= 1'b0;
            sel_q    <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                tx_mem[i]  <= '0;
                rx_mem[i]  <= '0;
                cmd_mem[i] <= '0;
            end
        end else begin
            if (cfg_wr) begin
                case (addr)
                    A_CLKCTL: clkctl_q <= wdata;
                    A_FIRST:  first_q  <= wdata[SW-1:0];
                    A_LAST:   last_q   <= wdata[SW-1:0];
                    A_RUNCTL: rc_q     <= '{cont: wdata[7], ie: wdata[5]};
                    A_DEVSEL: sel_q    <= wdata[CSW-1:0];
                    A_LOCK:   lock_q   <= wdata[0];
                    default: begin
                        if (is_tx && !addr[0]) tx_mem[addr[SW:1]] <= wdata[7:0];
                        if (is_cmd) cmd_mem[addr[SW-1:0]] <= wdata[7:0];
                    end
                endcase
            end
            if (wr && addr == A_STATUS && !wdata[0]) stat_q <= 1'b0;
            if (done_set) stat_q <= 1'b1;
            if (rx_we) rx_mem[slot] <= rx_data;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CLKCTL: rdata = clkctl_q;
            A_FIRST:  rdata[SW-1:0] = first_q;
            A_LAST:   rdata[SW-1:0] = last_q;
            A_RUNCTL: rdata[7:5] = {rc_q.cont, active, rc_q.ie};
            A_STATUS: rdata[0] = stat_q;
            A_DEVSEL: rdata[CSW-1:0] = sel_q;
            A_LOCK:   rdata[0] = lock_q;
            default: begin
                if (is_tx && !addr[0]) rdata[7:0] = tx_mem[addr[SW:1]];
                if (is_rx && addr[0])  rdata[7:0] = rx_mem[addr[SW:1]];
                if (is_cmd)            rdata[7:0] = cmd_mem[addr[SW-1:0]];
            end
        endcase
    end

    assign first_ptr = first_q;
    assign last_ptr  = last_q;
    assign div       = eff_div(clkctl_q[7:0]);
    assign runctl    = rc_q;
    assign devsel    = sel_q;
    assign tx_byte   = tx_mem[slot];
    assign slot_hold = cmd_mem[slot][7];
    assign irq       = stat_q && rc_q.ie;

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        active |=> ($stable(first_q) && $stable(last_q) && $stable(clkctl_q)));
    p_done_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        done_set |=> stat_q);
endmodule

// File: rtl/qsm_shifter.sv
module qsm_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic [7:0] div,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);
    logic [7:0] cnt;
    logic [2:0] nbit;
    logic [7:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sck  <= 1'b1;
            mosi <= 1'b1;
            cnt  <= '0;
            nbit <= '0;
            sh   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                busy <= 1'b1;
                sck  <= 1'b0;
                mosi <= tx[7];
                sh   <= tx;
                cnt  <= '0;
                nbit <= '0;
            end else if (busy) begin
                if (cnt == div - 8'd1) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        sh  <= {sh[6:0], miso};
                    end else if (nbit == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        sck  <= 1'b0;
                        mosi <= sh[7];
                        nbit <= nbit + 3'd1;
                    end
                end else begin
                    cnt <= cnt + 8'd1;
                end
            end
        end
    end

    assign rx = sh;

    p_sck_idle_high_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck);
    p_mosi_hold_high_r2: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/qsm_sequencer.sv
module qsm_sequencer
    import qsm_pkg::*;
#(
    parameter int SLOTS = QSM_SLOTS,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [SW-1:0] first_ptr,
    input  logic [SW-1:0] last_ptr,
    input  logic [7:0]    div,
    input  logic          slot_hold,
    input  logic          end_cont,
    input  logic          sh_done,
    output logic [SW-1:0] slot,
    output logic          active,
    output logic          go,
    output logic          cs_on,
    output logic          rx_we,
    output logic          done_set
);
    seq_state_t st;
    logic [7:0] gcnt;

    assign active   = (st != SQ_IDLE);
    assign go       = (st == SQ_LOAD);
    assign rx_we    = (st == SQ_XFER) && sh_done;
    assign done_set = rx_we && (slot == last_ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            slot  <= '0;
            gcnt  <= '0;
            cs_on <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    slot <= first_ptr;
                    st   <= SQ_LOAD;
                end
                SQ_LOAD: begin
                    cs_on <= 1'b1;
                    st    <= SQ_XFER;
                end
                SQ_XFER: if (sh_done) begin
                    if (slot == last_ptr) begin
                        cs_on <= slot_hold && end_cont;
                        st    <= SQ_IDLE;
                    end else begin
                        slot <= slot + 1'b1;
                        if (slot_hold) begin
                            st <= SQ_LOAD;
                        end else begin
                            cs_on <= 1'b0;
                            gcnt  <= '0;
                            st    <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    gcnt <= gcnt + 8'd1;
                    if (gcnt == div - 8'd1) st <= SQ_LOAD;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/queued_spi_master.sv
module queued_spi_master
    import qsm_pkg::*;
#(
    parameter int SLOTS = QSM_SLOTS,
    parameter int AW    = QSM_AW,
    parameter int DW    = QSM_DW,
    parameter int CSW   = QSM_CSW,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           spi_sck,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [CSW-1:0] spi_cs_n,
    output logic           irq
);
    logic          start, active, done_set, rx_we, go, cs_on;
    logic          slot_hold, sh_done, sh_busy;
    logic [SW-1:0] slot, first_ptr, last_ptr;
    logic [7:0]    div, tx_byte, rx_byte;
    logic [CSW-1:0] devsel;
    runctl_t       runctl;

    qsm_regfile #(.SLOTS(SLOTS), .AW(AW), .DW(DW), .CSW(CSW)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .active(active), .done_set(done_set), .rx_we(rx_we),
        .slot(slot), .rx_data(rx_byte), .start(start), .first_ptr(first_ptr),
        .last_ptr(last_ptr), .div(div), .runctl(runctl), .devsel(devsel),
        .tx_byte(tx_byte), .slot_hold(slot_hold), .irq(irq)
    );

    qsm_sequencer #(.SLOTS(SLOTS)) u_seq (
        .clk(clk), .rst(rst), .start(start), .first_ptr(first_ptr),
        .last_ptr(last_ptr), .div(div), .slot_hold(slot_hold),
        .end_cont(runctl.cont), .sh_done(sh_done), .slot(slot),
        .active(active), .go(go), .cs_on(cs_on), .rx_we(rx_we),
        .done_set(done_set)
    );

    qsm_shifter u_shift (
        .clk(clk), .rst(rst), .go(go), .tx(tx_byte), .div(div),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(sh_busy),
        .done(sh_done), .rx(rx_byte)
    );

    assign spi_cs_n = ~(devsel & {CSW{cs_on}});

    p_cs_covers_shift_r6: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> cs_on);
    p_no_shift_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sh_busy);
endmodule

// File: tb/queued_spi_master_bench.sv
`timescale 1ns/1ps
module queued_spi_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b1;
    logic [7:0]  spi_cs_n;
    logic        irq;

    int nchk = 0, nfail = 0;
    logic armed = 1'b0;

    always #10 clk = ~clk;

    queued_spi_master u_queued_spi_master (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
    );

    // serial device model
    int kbyte = 0, bitc = 0, csrel = 0, lowlen = 0;
    logic [7:0] cap = '0;
    logic [7:0] got [1024];
    logic [7:0] cs_seen = '1;
    time tfall = 0;

    function automatic logic [7:0] resp_of(input int k);
        return 8'((k * 37 + 91) ^ (k >> 3));
    endfunction

    always @(negedge spi_sck) if (armed) begin
        logic [7:0] r;
        r = resp_of(kbyte);
        spi_miso <= r[7 - bitc];
        tfall = $time;
    end

    always @(posedge spi_sck) if (armed) begin
        lowlen = int'(($time - tfall) / 20);
        cs_seen = spi_cs_n;
        cap = {cap[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            got[kbyte % 1024] = cap;
            kbyte++;
            bitc = 0;
        end
    end

    wire cs_all_high = &spi_cs_n;
    always @(posedge cs_all_high) if (armed) csrel++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    logic [7:0] tx_v [16];
    bit         hold_v [16];

    task automatic setup_q(input int st, input int en, input int dv, input int sel);
        wr(7'h00, 32'(dv) | 32'h0000_2300);
        wr(7'h05, 32'(sel));
        for (int s = 0; s < 16; s++) begin
            wr(7'(8'h20 + 2 * s), 32'(tx_v[s]));
            wr(7'(8'h60 + s), hold_v[s] ? 32'h8E : 32'h0E);
        end
        wr(7'h01, 32'(st));
        wr(7'h02, 32'(en));
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int g = 0; g < 12000; g++) begin
            rd(7'h04, v);
            if (v[0]) begin ok = 1; break; end
        end
    endtask

    task automatic check_q(input int st, input int en, input bit cont,
                           input int k0, input int r0, input bit ok);
        int n, rel;
        logic [31:0] v;
        n = ((en - st) & 15) + 1;
        check(ok, "R7 run completes", ok, 1);
        check(kbyte - k0 == n, "R2 byte count", kbyte - k0, n);
        rel = 0;
        for (int i = 0; i < n; i++) begin
            int s;
            s = (st + i) & 15;
            check(got[(k0 + i) % 1024] == tx_v[s], "R2 sent byte", got[(k0 + i) % 1024], tx_v[s]);
            rd(7'(8'h40 + 2 * s + 1), v);
            check(v == 32'(resp_of(k0 + i)), "R3 received byte", v, resp_of(k0 + i));
            if (i < n - 1 && !hold_v[s]) rel++;
        end
        if (!(hold_v[en] && cont)) rel++;
        check(csrel - r0 == rel, "R5 chip-select releases", csrel - r0, rel);
    endtask

    task automatic run_q(input int st, input int en, input bit cont,
                         input bit ie, input int dv, input int sel);
        int k0, r0;
        bit ok;
        setup_q(st, en, dv, sel);
        k0 = kbyte; r0 = csrel;
        wr(7'h03, (32'(cont) << 7) | 32'h40 | (32'(ie) << 5));
        wait_done(ok);
        check_q(st, en, cont, k0, r0, ok);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R7 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int k0, r0;
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        armed = 1'b1;

        // R1 reset state
        rd(7'h04, v);
        check(v == 0, "R1 status after reset", v, 0);
        check(spi_cs_n == 8'hFF, "R1 cs_n after reset", spi_cs_n, 8'hFF);
        check(spi_sck == 1'b1, "R1 sck idle", spi_sck, 1);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R10 write lock
        wr(7'h06, 32'h1); rd(7'h06, v);
        check(v == 1, "R10 lock set", v, 1);
        wr(7'h06, 32'h0); rd(7'h06, v);
        check(v == 0, "R10 lock clear", v, 0);

        // directed: three slots, all gaps, divider 10, device 2, irq on
        for (int s = 0; s < 16; s++) begin tx_v[s] = 8'(s * 17 + 3); hold_v[s] = 0; end
        run_q(0, 2, 0, 1, 10, 8'h04);
        check(lowlen == 10, "R4 half period 10", lowlen, 10);
        check(cs_seen == 8'hFB, "R6 one-hot select", cs_seen, 8'hFB);
        check(irq == 1'b1, "R8 irq with enable", irq, 1);
        rd(7'h03, v);
        check(v[6] == 1'b0, "R7 run bit after run", v[6], 0);
        wr(7'h04, 32'h0);
        rd(7'h04, v);
        check(v == 0, "R7 status clear", v, 0);
        check(irq == 1'b0, "R8 irq after clear", irq, 0);

        // divider clamp, irq disabled, wrap 14..1
        for (int s = 0; s < 16; s++) tx_v[s] = 8'(8'hC0 ^ s);
        run_q(14, 1, 0, 0, 3, 8'h80);
        check(lowlen == 8, "R4 clamped divider", lowlen, 8);
        check(irq == 1'b0, "R8 irq masked", irq, 0);
        wr(7'h04, 32'h0);

        // R5 hold after last slot with continue bit
        for (int s = 0; s < 16; s++) hold_v[s] = 1;
        run_q(4, 6, 1, 0, 8, 8'h01);
        check(spi_cs_n == 8'hFE, "R5 held after last slot", spi_cs_n, 8'hFE);
        wr(7'h04, 32'h0);
        hold_v[7] = 0;
        run_q(7, 7, 0, 0, 8, 8'h01);
        check(spi_cs_n == 8'hFF, "R5 released after last slot", spi_cs_n, 8'hFF);
        wr(7'h04, 32'h0);

        // R9 writes during a run ignored; R7 run bit during run
        for (int s = 0; s < 16; s++) begin tx_v[s] = 8'(s + 8'h50); hold_v[s] = 0; end
        setup_q(0, 1, 9, 8'h02);
        k0 = kbyte; r0 = csrel;
        wr(7'h03, 32'h40);
        rd(7'h03, v);
        check(v[6] == 1'b1, "R7 run bit during run", v[6], 1);
        wr(7'h20 + 7'd2, 32'hAA);
        wr(7'h01, 32'h9);
        wr(7'h00, 32'h0C);
        wait_done(ok);
        check_q(0, 1, 0, k0, r0, ok);
        rd(7'h22, v);
        check(v == 32'h51, "R9 tx slot unchanged", v, 32'h51);
        rd(7'h01, v);
        check(v == 0, "R9 first pointer unchanged", v, 0);
        rd(7'h00, v);
        check(v == 32'h2309, "R9 clock control unchanged", v, 32'h2309);
        wr(7'h04, 32'h0);

        // random runs
        for (int r = 0; r < 10; r++) begin
            int st, en, dv, sel;
            for (int s = 0; s < 16; s++) begin
                tx_v[s] = 8'($urandom);
                hold_v[s] = $urandom_range(0, 1) == 1;
            end
            st = $urandom_range(0, 15);
            en = $urandom_range(0, 15);
            dv = $urandom_range(8, 11);
            sel = 1 << $urandom_range(0, 7);
            run_q(st, en, 0, 1, dv, sel);
            check(lowlen == dv, "R4 random half period", lowlen, dv);
            wr(7'h04, 32'h0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule